// File: doc/BRIEF.md
# Burst Replay Controller

This block captures one burst of words from a streaming source into an on-chip buffer and replays that buffer to a streaming sink, all in a single clock domain. The whole buffer is handled as one packet. A fill ends on the first beat that carries the end-of-burst flag, when the buffer is full, or when a hardware start event cuts it short. Replay then runs either once or in an endless loop.

When replay starts is set by a 2-bit start-mode input. In automatic mode, replay starts as soon as the buffer is complete. In hardware mode, a pulse on an external sync line starts it. In software mode, a single-cycle trigger pulse starts it. The fourth code is reserved and never starts replay.

A restart request clears the buffer and opens it for a new fill. A synchronous soft reset, active low, returns the controller to its idle state. The current states of the fill side and the replay side are exported as small codes for debug.

Top module: `burst_replay_ctrl`

## Requirements
- R1: While `rst_n` or `soft_rst_n` is low at a clock edge, the following hold after that edge: `wr_state` = 0 (idle), `rd_state` = 0 (waiting), `s_ready` = 0 and `m_valid` = 0. No beat is accepted until a restart request arrives.
- R2: A cycle with `init_req` high (and `soft_rst_n` high) empties the buffer. After the next edge, `wr_state` = 1 (filling), `s_ready` = 1 and `rd_state` = 0. A beat offered in that same cycle is discarded.
- R3: While filling, each accepted beat is stored in arrival order. The fill completes (`wr_state` = 2) on a beat with `s_last` high or on the DEPTH-th stored beat. Beats offered after completion are accepted (`s_ready` = 1) and discarded.
- R4: With `sync_mode` = 0, replay starts by itself in the cycle after the fill completes (`rd_state` = 1).
- R5: With `sync_mode` = 1, an `ext_sync` pulse starts replay. If the pulse arrives during a fill that holds at least one word (counting a beat accepted in that same cycle), the fill ends there. Only the words stored up to that point are replayed, and later source beats are dropped.
- R6: With `sync_mode` = 2, a `sw_trig` pulse starts replay of a completed buffer. A `sw_trig` pulse before completion, and any `ext_sync` pulse, has no effect.
- R7: With `sync_mode` = 3, replay never starts, whatever `ext_sync` and `sw_trig` do.
- R8: With `oneshot` = 0, the stored words are replayed in order without end. After the last stored word, replay continues from the first.
- R9: With `oneshot` = 1, each stored word is presented once. Then `rd_state` = 2 (halted) and `m_valid` stays low until a restart request.
- R10: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` is unchanged in the next cycle.
- R11: `wr_state` encodes idle = 0, filling = 1, complete = 2. `rd_state` encodes waiting = 0, replaying = 1, halted = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst_n | input | 1 | Synchronous soft reset of all state and addresses, active low |
| init_req | input | 1 | Restart request: empty the buffer and open it for a new fill |
| sync_mode | input | 2 | Start mode: 0 auto, 1 hardware, 2 software, 3 reserved |
| oneshot | input | 1 | 1 = replay once then halt, 0 = replay in a loop |
| ext_sync | input | 1 | External start pulse (hardware mode) |
| sw_trig | input | 1 | Single-cycle software start pulse |
| s_valid | input | 1 | Source beat valid |
| s_ready | output | 1 | Source beat accepted |
| s_data | input | DATA_W | Source beat payload |
| s_last | input | 1 | Source end-of-burst flag |
| m_valid | output | 1 | Sink beat valid |
| m_ready | input | 1 | Sink ready |
| m_data | output | DATA_W | Sink beat payload |
| wr_state | output | 2 | Fill-side state code |
| rd_state | output | 2 | Replay-side state code |

## Verification
The bench targets these corner cases:
- A hardware sync that arrives in the same cycle as a source beat. A design that misses the accepted beat replays one word too few; one that ignores the cut keeps filling.
- A fill that reaches DEPTH words without an end flag. A wrong design overruns the buffer or never completes.
- The wrap from the last stored word back to the first in loop mode. A fault here repeats the last word or replays stale entries.
- The exit from one-shot replay. A fault here drops the last word or keeps replaying.

It also stalls the sink while a word is pending, to catch a design that advances or drops valid under back-pressure. It fires triggers in the wrong mode and before the buffer is complete, to catch a start gate that decodes the mode loosely.

// File: rtl/brc_pkg.sv
// Shared types for the burst replay controller.
// Assumes: the state codes below are visible on debug ports and must not change.
package brc_pkg;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_FILL = 2'd1,
        WR_DONE = 2'd2
    } wr_st_t;

    typedef enum logic [1:0] {
        RD_WAIT = 2'd0,
        RD_PLAY = 2'd1,
        RD_HALT = 2'd2
    } rd_st_t;

    localparam logic [1:0] SYNC_AUTO = 2'd0;
    localparam logic [1:0] SYNC_HW   = 2'd1;
    localparam logic [1:0] SYNC_SW   = 2'd2;

endpackage

// File: rtl/brc_buf_ram.sv
// Buffer storage: one synchronous write port and one combinational read port.
// Assumes: the read side only addresses words that the fill side has written.
module brc_buf_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the accepted source word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/brc_fill_ctrl.sv
// Fill-side sequencer: accepts source beats into the buffer and records the
// index of the final stored word.
// Assumes: clr is the restart/soft-reset strobe and arm is set only when a
// restart request is not overridden by the soft reset.
module brc_fill_ctrl
    import brc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              arm,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic              cut,
    output logic              s_ready,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W-1:0] last_addr,
    output logic              has_data,
    output wr_st_t            state
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

    wr_st_t            state_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [ADDR_W-1:0] last_q;

    assign s_ready   = (state_q != WR_IDLE);
    assign we        = (state_q == WR_FILL) && s_valid && !clr;
    assign has_data  = (waddr_q != '0);
    assign waddr     = waddr_q;
    assign last_addr = last_q;
    assign state     = state_q;

    // Advance the write pointer and close the fill on end flag, full or cut.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            waddr_q <= '0;
            last_q  <= '0;
        end else if (clr) begin
            state_q <= arm ? WR_FILL : WR_IDLE;
            waddr_q <= '0;
            last_q  <= '0;
        end else if (state_q == WR_FILL) begin
            if (we) begin
                waddr_q <= waddr_q + ONE;
                if (s_last || (waddr_q == TOP_ADDR) || cut) begin
                    state_q <= WR_DONE;
                    last_q  <= waddr_q;
                end
            end else if (cut) begin
                state_q <= WR_DONE;
                last_q  <= waddr_q - ONE;
            end
        end
    end

    // R3
    full_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state_q == WR_FILL) && we && (waddr_q == TOP_ADDR) |=> (state_q == WR_DONE));

    // R5
    cut_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state_q == WR_FILL) && cut |=> (state_q == WR_DONE));

endmodule

// File: rtl/brc_start_gate.sv
// Start decoder: turns the start mode and the trigger pulses into a fill cut
// and a replay start.
// Assumes: all inputs are synchronous to the controller clock.
module brc_start_gate
    import brc_pkg::*;
(
    input  logic [1:0] sync_mode,
    input  logic       ext_sync,
    input  logic       sw_trig,
    input  logic       filling,
    input  logic       has_data,
    input  logic       beat_in,
    input  logic       buf_done,
    input  logic       rd_wait,
    output logic       cut,
    output logic       start
);

    logic done_go;

    // Hardware sync closes a fill early once at least one word is in.
    assign cut = (sync_mode == SYNC_HW) && ext_sync && filling && (has_data || beat_in);

    // Pick the start condition for a completed buffer.
    always_comb begin
        unique case (sync_mode)
            SYNC_AUTO: done_go = buf_done;
            SYNC_HW:   done_go = buf_done && ext_sync;
            SYNC_SW:   done_go = buf_done && sw_trig;
            default:   done_go = 1'b0;
        endcase
    end

    assign start = rd_wait && (cut || done_go);

endmodule

// File: rtl/brc_play_ctrl.sv
// Replay sequencer: reads the buffer into a registered output stage, honours
// sink back-pressure, loops or halts at the last stored word.
// Assumes: last_addr is stable whenever replay is active.
module brc_play_ctrl
    import brc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start,
    input  logic              oneshot,
    input  logic              m_ready,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output rd_st_t            state
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    rd_st_t            state_q;
    logic [ADDR_W-1:0] raddr_q;
    logic              fin_q;
    logic              m_valid_q;
    logic [DATA_W-1:0] m_data_q;
    logic              load;

    assign load    = !m_valid_q || m_ready;
    assign raddr   = raddr_q;
    assign m_valid = m_valid_q;
    assign m_data  = m_data_q;
    assign state   = state_q;

    // Step through the buffer each time the output stage is free.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q   <= RD_WAIT;
            raddr_q   <= '0;
            fin_q     <= 1'b0;
            m_valid_q <= 1'b0;
            m_data_q  <= '0;
        end else begin
            unique case (state_q)
                RD_WAIT: begin
                    if (start) begin
                        state_q <= RD_PLAY;
                        raddr_q <= '0;
                        fin_q   <= 1'b0;
                    end
                end
                RD_PLAY: begin
                    if (load) begin
                        if (!fin_q) begin
                            m_valid_q <= 1'b1;
                            m_data_q  <= rdata;
                            if (raddr_q == last_addr) begin
                                if (oneshot) begin
                                    fin_q <= 1'b1;
                                end else begin
                                    raddr_q <= '0;
                                end
                            end else begin
                                raddr_q <= raddr_q + ONE;
                            end
                        end else begin
                            m_valid_q <= 1'b0;
                            state_q   <= RD_HALT;
                        end
                    end
                end
                default: begin
                    state_q <= RD_HALT;
                end
            endcase
        end
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        m_valid_q && !m_ready |=> m_valid_q && $stable(m_data_q));

    // R9
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state_q == RD_HALT) |-> !m_valid_q);

endmodule

// File: rtl/burst_replay_ctrl.sv
// Top of the burst replay controller: buffer, fill side, start decoder and
// replay side.
// Assumes: single clock; depth is at least 2; sink and source follow a
// valid/ready handshake.
module burst_replay_ctrl
    import brc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_n,
    input  logic              init_req,
    input  logic [1:0]        sync_mode,
    input  logic              oneshot,
    input  logic              ext_sync,
    input  logic              sw_trig,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic [1:0]        wr_state,
    output logic [1:0]        rd_state
);

    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              clr;
    logic              arm;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [ADDR_W-1:0] last_addr;
    logic [DATA_W-1:0] rdata;
    logic              has_data;
    logic              cut;
    logic              start;
    wr_st_t            wst;
    rd_st_t            rst;

    assign clr = !soft_rst_n || init_req;
    assign arm = soft_rst_n && init_req;

    brc_buf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) ram_i (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (s_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    brc_fill_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) fill_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .arm       (arm),
        .s_valid   (s_valid),
        .s_last    (s_last),
        .cut       (cut),
        .s_ready   (s_ready),
        .we        (we),
        .waddr     (waddr),
        .last_addr (last_addr),
        .has_data  (has_data),
        .state     (wst)
    );

    brc_start_gate gate_i (
        .sync_mode (sync_mode),
        .ext_sync  (ext_sync),
        .sw_trig   (sw_trig),
        .filling   (wst == WR_FILL),
        .has_data  (has_data),
        .beat_in   (we),
        .buf_done  (wst == WR_DONE),
        .rd_wait   (rst == RD_WAIT),
        .cut       (cut),
        .start     (start)
    );

    brc_play_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) play_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .start     (start),
        .oneshot   (oneshot),
        .m_ready   (m_ready),
        .last_addr (last_addr),
        .rdata     (rdata),
        .raddr     (raddr),
        .m_valid   (m_valid),
        .m_data    (m_data),
        .state     (rst)
    );

    assign wr_state = wst;
    assign rd_state = rst;

    // R7
    rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (rd_state == 2'd0) && (sync_mode == 2'd3) |=> (rd_state == 2'd0));

    // R6
    sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (rd_state == 2'd0) && (sync_mode == 2'd2) && !sw_trig |=> (rd_state == 2'd0));

    // R4
    auto_go_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (rd_state == 2'd0) && (wr_state == 2'd2) && (sync_mode == 2'd0) |=> (rd_state == 2'd1));

endmodule

// File: tb/burst_replay_ctrl_tb.sv
// Bench for the burst replay controller. A behavioural reference model
// (queue-based) runs alongside the design and is compared every cycle.
module burst_replay_ctrl_tb_top;

    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              soft_rst_n = 1'b1;
    logic              init_req = 1'b0;
    logic [1:0]        sync_mode = 2'd0;
    logic              oneshot = 1'b0;
    logic              ext_sync = 1'b0;
    logic              sw_trig = 1'b0;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [DATA_W-1:0] s_data = '0;
    logic              s_last = 1'b0;
    logic              m_valid;
    logic              m_ready = 1'b1;
    logic [DATA_W-1:0] m_data;
    logic [1:0]        wr_state;
    logic [1:0]        rd_state;

    always #5 clk = ~clk;

    burst_replay_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_n (soft_rst_n),
        .init_req   (init_req),
        .sync_mode  (sync_mode),
        .oneshot    (oneshot),
        .ext_sync   (ext_sync),
        .sw_trig    (sw_trig),
        .s_valid    (s_valid),
        .s_ready    (s_ready),
        .s_data     (s_data),
        .s_last     (s_last),
        .m_valid    (m_valid),
        .m_ready    (m_ready),
        .m_data     (m_data),
        .wr_state   (wr_state),
        .rd_state   (rd_state)
    );

    int  n_vec  = 0;
    int  n_bad  = 0;
    int  played = 0;
    int  sink_mode = 0;   // 0 always ready, 1 random, 2 stalled
    bit  cmp_en = 1'b0;
    bit  done_flag = 1'b0;

    // Reference model state.
    int                ref_ws = 0;
    int                ref_rs = 0;
    int                ref_rp = 0;
    bit                ref_fin = 1'b0;
    bit                ref_mv = 1'b0;
    logic [DATA_W-1:0] ref_md = '0;
    logic [DATA_W-1:0] ref_q[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        bit cut_e;
        bit start_e;
        if (m_valid && m_ready && rst_n) played++;
        if (!rst_n || !soft_rst_n) begin
            ref_ws = 0; ref_rs = 0; ref_rp = 0; ref_fin = 0; ref_mv = 0; ref_md = '0;
            ref_q.delete();
        end else if (init_req) begin
            ref_ws = 1; ref_rs = 0; ref_rp = 0; ref_fin = 0; ref_mv = 0; ref_md = '0;
            ref_q.delete();
        end else begin
            cut_e = (sync_mode == 2'd1) && ext_sync && (ref_ws == 1) &&
                    ((ref_q.size() > 0) || s_valid);
            start_e = (ref_rs == 0) && (cut_e || ((ref_ws == 2) &&
                      ((sync_mode == 2'd0) || (sync_mode == 2'd1 && ext_sync) ||
                       (sync_mode == 2'd2 && sw_trig))));
            if (ref_rs == 0) begin
                if (start_e) begin ref_rs = 1; ref_rp = 0; ref_fin = 0; end
            end else if (ref_rs == 1) begin
                if (!ref_mv || m_ready) begin
                    if (!ref_fin) begin
                        ref_mv = 1;
                        ref_md = ref_q[ref_rp];
                        if (ref_rp == ref_q.size() - 1) begin
                            if (oneshot) ref_fin = 1;
                            else ref_rp = 0;
                        end else begin
                            ref_rp++;
                        end
                    end else begin
                        ref_mv = 0;
                        ref_rs = 2;
                    end
                end
            end
            if (ref_ws == 1) begin
                if (s_valid) begin
                    ref_q.push_back(s_data);
                    if (s_last || ref_q.size() == DEPTH || cut_e) ref_ws = 2;
                end else if (cut_e) begin
                    ref_ws = 2;
                end
            end
        end
    end

    // Cycle compare between edges.
    always @(negedge clk) begin
        if (cmp_en && !done_flag) begin
            chk(s_ready == (ref_ws != 0), "R3 s_ready", s_ready, (ref_ws != 0));
            chk(wr_state == 2'(ref_ws), "R11 wr_state", wr_state, ref_ws);
            chk(rd_state == 2'(ref_rs), "R11 rd_state", rd_state, ref_rs);
            chk(m_valid == ref_mv, "R4 m_valid", m_valid, ref_mv);
            if (ref_mv) chk(m_data == ref_md, "R8 m_data", m_data, ref_md);
        end
    end

    // Sink ready pattern.
    always @(negedge clk) begin
        case (sink_mode)
            1:       m_ready = ($urandom_range(0, 3) != 0);
            2:       m_ready = 1'b0;
            default: m_ready = 1'b1;
        endcase
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
        played = 0;
    endtask

    task automatic send_beat(input logic [DATA_W-1:0] d, input bit last, input bit sync);
        @(negedge clk);
        s_valid = 1'b1; s_data = d; s_last = last; ext_sync = sync;
        while (!s_ready) @(negedge clk);
    endtask

    task automatic end_src();
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0; ext_sync = 1'b0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_sync = 1'b1;
        @(negedge clk); ext_sync = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        finish_run();
    end

    initial begin
        logic [DATA_W-1:0] held;
        tick(3);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        tick(1);
        // R1 reset state
        chk(wr_state == 2'd0 && rd_state == 2'd0, "R1 states", {wr_state, rd_state}, 0);
        chk(!s_ready && !m_valid, "R1 handshake", {s_ready, m_valid}, 0);

        // R2 restart opens a fill
        sync_mode = 2'd0; oneshot = 1'b0;
        restart();
        chk(wr_state == 2'd1 && s_ready, "R2 fill open", wr_state, 1);

        // R4/R8 auto start, loop replay with random back-pressure
        sink_mode = 1;
        for (int i = 0; i < 5; i++) send_beat(32'h100 + i, i == 4, 1'b0);
        end_src();
        tick(40);
        chk(rd_state == 2'd1, "R8 still replaying", rd_state, 1);
        chk(played > 5, "R8 wrapped", played, 6);

        // R9 one-shot auto
        oneshot = 1'b1;
        restart();
        for (int i = 0; i < 7; i++) send_beat(32'h200 + i, i == 6, 1'b0);
        end_src();
        tick(40);
        chk(played == 7, "R9 words once", played, 7);
        chk(rd_state == 2'd2 && !m_valid, "R9 halted", rd_state, 2);

        // R5 hardware sync cuts the fill, beat in same cycle kept
        sink_mode = 0;
        sync_mode = 2'd1;
        restart();
        for (int i = 0; i < 6; i++) send_beat(32'h300 + i, 1'b0, 1'b0);
        send_beat(32'h306, 1'b0, 1'b1);
        for (int i = 7; i < 12; i++) send_beat(32'h300 + i, 1'b0, 1'b0);
        end_src();
        tick(30);
        chk(played == 7, "R5 cut length", played, 7);
        chk(wr_state == 2'd2, "R5 fill closed", wr_state, 2);

        // R6 software trigger: early trigger and ext_sync ignored
        sync_mode = 2'd2;
        restart();
        pulse_sw();
        for (int i = 0; i < 4; i++) send_beat(32'h400 + i, i == 3, 1'b0);
        end_src();
        pulse_ext();
        tick(10);
        chk(rd_state == 2'd0 && played == 0, "R6 no early start", played, 0);
        pulse_sw();
        tick(30);
        chk(played == 4, "R6 triggered replay", played, 4);

        // R7 reserved mode never starts
        sync_mode = 2'd3;
        restart();
        for (int i = 0; i < 3; i++) send_beat(32'h500 + i, i == 2, 1'b0);
        end_src();
        pulse_sw();
        pulse_ext();
        tick(10);
        chk(rd_state == 2'd0 && played == 0, "R7 reserved idle", played, 0);

        // R3 full buffer without end flag, extra beats discarded
        sync_mode = 2'd0;
        restart();
        for (int i = 0; i < DEPTH + 4; i++) send_beat(32'h600 + i, 1'b0, 1'b0);
        end_src();
        tick(60);
        chk(played == DEPTH, "R3 full length", played, DEPTH);
        chk(wr_state == 2'd2, "R3 fill complete", wr_state, 2);

        // R10 back-pressure holds the pending word
        oneshot = 1'b0;
        sink_mode = 2;
        restart();
        for (int i = 0; i < 3; i++) send_beat(32'h700 + i, i == 2, 1'b0);
        end_src();
        for (int k = 0; k < 20 && !m_valid; k++) tick(1);
        held = m_data;
        tick(5);
        chk(m_valid == 1'b1, "R10 valid held", m_valid, 1);
        chk(m_data == held, "R10 data held", m_data, held);
        sink_mode = 0;
        tick(10);

        // R1 soft reset during replay
        @(negedge clk); soft_rst_n = 1'b0;
        @(negedge clk); soft_rst_n = 1'b1;
        chk(wr_state == 2'd0 && rd_state == 2'd0, "R1 soft states", {wr_state, rd_state}, 0);
        chk(!m_valid && !s_ready, "R1 soft handshake", {s_ready, m_valid}, 0);
        tick(3);
        finish_run();
    end

endmodule